// File: doc/BRIEF.md
# Indirect Oscillator Configuration Channel

This block lets software read and write a small bank of oscillator-frequency words. It does so through a command register instead of a direct address window. Software first places the value to be written in an outbound data word. It then writes the command word with a device number, a function code, a direction flag and a launch flag. The block carries out the transfer in the same clock cycle as that command write. Completion and any error show in a status word, and a read result lands in a return data word.

The bank depth and the reset value of each entry are parameters. The current value of every entry is also driven on an output vector, so that neighbouring clock logic can use it. Only function code 1 with a device number below the bank depth is a valid target. Any other target flags an error, and no data moves.

Top module: `cfgch_ctrl`

## Requirements
- R1: A command-word write keeps device [11:0], function [25:20] and the direction flag [30]. Bits [19:12], [29:26] and the launch flag [31] always read back as 0.
- R2: Every command-word write clears the status word. A write with launch = 0 leaves it at 0. When there is no command write, the status word holds its value.
- R3: A command-word write with launch = 1 sets status bit 0 (done), and the next bus read sees it.
- R4: A valid launch with direction = 1 copies the outbound data word into the addressed bank entry.
- R5: A valid launch with direction = 0 copies the addressed bank entry into the return data word.
- R6: A launch with function != 1 or device >= bank depth sets status bit 1 (error) together with done. It changes neither any bank entry nor the return data word.
- R7: After reset the command word reads 0x00100000. The status, return and outbound words read 0, and bank entry i holds its own parameter reset value.
- R8: The register map is: return data at 0xA0 (read-only), outbound data at 0xA4, command at 0xA8, status at 0xAC (read-only). Any other address reads 0, and writes to it have no effect.
- R9: Output `osc_values` shows bank entry i in bits [32*i+31:32*i] at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write access, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address (combinational) |
| osc_values | output | 32*N_OSC | Current bank contents, entry 0 in the low word |

## Verification
The hardest case to reach is a launch whose target sits exactly on the range boundary: device equal to the bank depth, or function 1 paired with the largest device number. Only there does the error path have to leave both the bank and the return word untouched. Directed commands hit device N_OSC-1, N_OSC, 0xFFF and function codes 0 and 63. Seeded random commands then mix valid and invalid targets, so the checks can see that failed reads keep a stale return value.

// File: rtl/cfgch_pkg.sv
package cfgch_pkg;
    localparam int unsigned WORD_W = 32;

    localparam logic [11:0] OFF_RTN  = 12'h0A0;
    localparam logic [11:0] OFF_DOUT = 12'h0A4;
    localparam logic [11:0] OFF_CMD  = 12'h0A8;
    localparam logic [11:0] OFF_STAT = 12'h0AC;

    // writable bits of the command word: direction, function, device
    localparam logic [31:0] CMD_KEEP  = 32'h43F0_0FFF;
    localparam logic [31:0] CMD_RESET = 32'h0010_0000;
    localparam int unsigned LAUNCH_BIT = 31;
    localparam int unsigned DIR_BIT    = 30;
    localparam logic [5:0]  FUNC_OSC   = 6'd1;

    typedef struct packed {
        logic [31:0] cmd;
        logic [1:0]  stat;   // [1] error, [0] done
        logic [31:0] rtn;
        logic [31:0] dout;
    } regs_t;
endpackage

// File: rtl/cfgch_cmd_decode.sv
module cfgch_cmd_decode #(
    parameter int unsigned N_OSC = 3,
    localparam int unsigned IDX_W = (N_OSC > 1) ? $clog2(N_OSC) : 1
) (
    input  logic [31:0]      cmd_word,
    output logic             is_write,
    output logic             target_ok,
    output logic [IDX_W-1:0] target_idx
);
    localparam logic [12:0] DEPTH_V = 13'(N_OSC);

    logic [11:0] dev;
    logic [5:0]  func;

    always_comb begin
        dev        = cmd_word[11:0];
        func       = cmd_word[25:20];
        is_write   = cmd_word[cfgch_pkg::DIR_BIT];
        target_ok  = (func == cfgch_pkg::FUNC_OSC) && ({1'b0, dev} < DEPTH_V);
        target_idx = dev[IDX_W-1:0];
    end
endmodule

// File: rtl/cfgch_osc_bank.sv
module cfgch_osc_bank #(
    parameter int unsigned N_OSC = 3,
    parameter logic [32*N_OSC-1:0] OSC_RST = '0,
    localparam int unsigned IDX_W = (N_OSC > 1) ? $clog2(N_OSC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   idx,
    input  logic [31:0]        wr_data,
    output logic [31:0]        rd_data,
    output logic [32*N_OSC-1:0] values
);
    logic [31:0] ent_q [N_OSC];
    logic [31:0] ent_d [N_OSC];

    for (genvar g = 0; g < N_OSC; g++) begin : g_ent
        always_comb begin
            ent_d[g] = ent_q[g];
            if (wr_en && (idx == IDX_W'(g))) ent_d[g] = wr_data;
        end
        always_ff @(posedge clk) begin
            if (!rst_n) ent_q[g] <= OSC_RST[32*g +: 32];
            else        ent_q[g] <= ent_d[g];
        end
        assign values[32*g +: 32] = ent_q[g];
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < N_OSC; i++)
            if (idx == IDX_W'(i)) rd_data = ent_q[i];
    end

    // R4: an entry only changes when it is the write target
    AST_BANK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(values)); // R4
endmodule

// File: rtl/cfgch_ctrl.sv
module cfgch_ctrl
    import cfgch_pkg::*;
#(
    parameter int unsigned N_OSC  = 3,
    parameter int unsigned ADDR_W = 12,
    parameter logic [32*N_OSC-1:0] OSC_RST = {32'd50_000_000, 32'd24_576_000, 32'd25_000_000},
    localparam int unsigned IDX_W = (N_OSC > 1) ? $clog2(N_OSC) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic [32*N_OSC-1:0] osc_values
);
    regs_t regs_q, regs_d;

    logic             cmd_wr, dout_wr, launch;
    logic             is_write, target_ok;
    logic [IDX_W-1:0] target_idx;
    logic             bank_we;
    logic [31:0]      bank_rd;

    // decode the incoming command word, not the stored one
    cfgch_cmd_decode #(.N_OSC(N_OSC)) i_dec (
        .cmd_word  (bus_wdata),
        .is_write  (is_write),
        .target_ok (target_ok),
        .target_idx(target_idx)
    );

    cfgch_osc_bank #(.N_OSC(N_OSC), .OSC_RST(OSC_RST)) i_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (bank_we),
        .idx    (target_idx),
        .wr_data(regs_q.dout),
        .rd_data(bank_rd),
        .values (osc_values)
    );

    always_comb begin
        regs_d  = regs_q;
        cmd_wr  = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFF_CMD));
        dout_wr = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFF_DOUT));
        launch  = cmd_wr && bus_wdata[LAUNCH_BIT];
        bank_we = launch && target_ok && is_write;

        if (dout_wr) regs_d.dout = bus_wdata;
        if (cmd_wr) begin
            regs_d.cmd  = bus_wdata & CMD_KEEP;
            regs_d.stat = 2'b00;
            if (launch) begin
                regs_d.stat = {!target_ok, 1'b1};
                if (target_ok && !is_write) regs_d.rtn = bank_rd;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q.cmd  <= CMD_RESET;
            regs_q.stat <= 2'b00;
            regs_q.rtn  <= '0;
            regs_q.dout <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFF_RTN))       bus_rdata = regs_q.rtn;
        else if (bus_addr == ADDR_W'(OFF_DOUT)) bus_rdata = regs_q.dout;
        else if (bus_addr == ADDR_W'(OFF_CMD))  bus_rdata = regs_q.cmd;
        else if (bus_addr == ADDR_W'(OFF_STAT)) bus_rdata = {30'd0, regs_q.stat};
    end

    AST_CMD_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr |=> regs_q.cmd == ($past(bus_wdata) & CMD_KEEP)); // R1
    AST_STAT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !bus_wdata[LAUNCH_BIT]) |=> regs_q.stat == 2'b00); // R2
    AST_STAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_wr |=> $stable(regs_q.stat)); // R2
    AST_LAUNCH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> regs_q.stat[0]); // R3
    AST_GOOD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && target_ok && is_write) |=>
        osc_values[32*$past(target_idx) +: 32] == $past(regs_q.dout)); // R4
    AST_BAD_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && !target_ok) |=>
        (regs_q.stat == 2'b11) && $stable(osc_values) && $stable(regs_q.rtn)); // R6
endmodule

// File: tb/test_cfgch_ctrl.sv
module test_cfgch_ctrl;
    localparam int unsigned N = 3;
    localparam logic [32*N-1:0] RST = {32'd50_000_000, 32'd24_576_000, 32'd25_000_000};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_sel = 1'b0, bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [32*N-1:0] osc_values;

    int checks = 0, errors = 0;
    logic [31:0] m_osc [N];
    logic [31:0] m_cmd, m_rtn, m_dout;
    logic [1:0]  m_stat;

    always #2.5 clk = ~clk;

    cfgch_ctrl #(.N_OSC(N), .ADDR_W(12), .OSC_RST(RST)) i_cfgch_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .osc_values(osc_values)
    );

    function automatic logic target_valid(input logic [31:0] c);
        return (c[25:20] == 6'd1) && (c[11:0] < 12'(N));
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        // model update
        if (a == 12'h0A4) m_dout = d;
        if (a == 12'h0A8) begin
            m_cmd  = d & 32'h43F0_0FFF;
            m_stat = 2'b00;
            if (d[31]) begin
                if (!target_valid(d)) m_stat = 2'b11;
                else begin
                    m_stat = 2'b01;
                    if (d[30]) m_osc[d[1:0]] = m_dout;
                    else       m_rtn = m_osc[d[1:0]];
                end
            end
        end
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic check_all(input string req);
        logic [31:0] v;
        rd(12'h0AC, v); check({req, " stat"}, v, {30'd0, m_stat});
        rd(12'h0A0, v); check({req, " rtn"}, v, m_rtn);
        rd(12'h0A8, v); check({req, " cmd"}, v, m_cmd);
        rd(12'h0A4, v); check({req, " dout"}, v, m_dout);
        for (int i = 0; i < N; i++) check({req, " R9 osc"}, osc_values[32*i +: 32], m_osc[i]);
    endtask

    initial begin
        #20000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int unsigned seed;
        seed = 32'd1234;
        v = $urandom(seed);
        for (int i = 0; i < N; i++) m_osc[i] = RST[32*i +: 32];
        m_cmd = 32'h0010_0000; m_rtn = '0; m_dout = '0; m_stat = 2'b00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R7 reset");

        // R1: reserved and launch bits dropped, no launch
        wr(12'h0A8, 32'h7FFF_FFFF);
        check_all("R1 masking");
        rd(12'h0A8, v); check("R1 cmd", v, 32'h43F0_0FFF);

        // R4 write last valid entry, R5 read it back
        wr(12'h0A4, 32'hCAFE_0001);
        wr(12'h0A8, 32'hC010_0000 | 32'(N - 1));
        rd(12'h0AC, v); check("R3 done next read", v, 32'h1);
        check_all("R4 write edge dev");
        wr(12'h0A8, 32'h8010_0000 | 32'(N - 1));
        check_all("R5 read back");
        rd(12'h0A0, v); check("R5 rtn", v, 32'hCAFE_0001);

        // R2 plain command write clears status
        wr(12'h0A8, 32'h0010_0001);
        rd(12'h0AC, v); check("R2 cleared", v, 32'h0);

        // R6 boundary device == N, all-ones device, bad function codes
        wr(12'h0A4, 32'hDEAD_BEEF);
        wr(12'h0A8, 32'hC010_0000 | 32'(N));
        rd(12'h0AC, v); check("R6 dev==N stat", v, 32'h3);
        check_all("R6 dev==N write");
        wr(12'h0A8, 32'h8010_0FFF);
        rd(12'h0A0, v); check("R6 stale rtn", v, 32'hCAFE_0001);
        check_all("R6 dev max read");
        wr(12'h0A8, 32'hC000_0000);
        check_all("R6 func 0");
        wr(12'h0A8, 32'h83F0_0000);
        check_all("R6 func 63");

        // R8 read-only and unmapped addresses
        wr(12'h0AC, 32'hFFFF_FFFF);
        wr(12'h0A0, 32'h1234_5678);
        wr(12'h0B0, 32'h1234_5678);
        check_all("R8 ignored writes");
        rd(12'h0B0, v); check("R8 unmapped read", v, 32'h0);
        rd(12'h000, v); check("R8 unmapped read low", v, 32'h0);

        // random mix
        for (int it = 0; it < 400; it++) begin
            logic [31:0] c;
            logic [11:0] dev;
            logic [5:0]  fn;
            int unsigned r;
            r = $urandom;
            if (r % 3 == 0) wr(12'h0A4, $urandom);
            else begin
                dev = (r % 8 < 5) ? 12'($urandom % N) :
                      ((r % 8 == 5) ? 12'hFFF : 12'(N + $urandom % 3));
                fn  = ($urandom % 5 != 0) ? 6'd1 : 6'($urandom);
                c = $urandom;
                c[11:0] = dev; c[25:20] = fn;
                c[31] = ($urandom % 6 != 0);
                wr(12'h0A8, c);
                check_all("R3 R4 R5 R6 random");
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule